// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block holds the 11-bit instruction address of a small processor core. Its program space is 2048 words, split into a low page (0x000–0x3FF) and a high page (0x400–0x7FF). Each cycle a 3-bit operation code tells the unit where the next instruction lies. It can step to the next word, hold, take a 10-bit in-page target, or return through an internal hardware stack.

Jumps, calls and computed writes to the counter's low part form the new address from the 10-bit target. The page-select bit of the core's status register supplies the top address bit. A call also saves the full 11-bit address of the following instruction. All three return flavours (plain, with literal, from interrupt) restore that saved address exactly. A return therefore lands in the page the call came from, whatever the page-select bit holds at that moment. Instruction decode and the program memory are outside this block.

Top module: `pc_paged_unit`

## Requirements
- R1: While reset is low, pc_o is 0x7FF. Reset clears every return-stack entry to 0x000 and marks the stack empty, so a return issued as the first operation after reset goes to 0x000.
- R2: Code 3'b001 (jump) sets pc_o, one clock later, to {page_sel_i, target_i}. page_sel_i forms bit 10.
- R3: Code 3'b010 (call) sets pc_o to {page_sel_i, target_i} one clock later. It also saves the full 11-bit value (old pc_o + 1) mod 2048 on the return stack.
- R4: Code 3'b110 (computed write of the low counter part) sets pc_o to {page_sel_i, target_i} one clock later. The stack is not touched.
- R5: Codes 3'b011, 3'b100 and 3'b101 (return, return with literal, return from interrupt) each set pc_o to the most recently saved address and remove it from the stack. target_i and page_sel_i have no effect on them.
- R6: Code 3'b000 (step) sets pc_o to (pc_o + 1) mod 2048, so 0x7FF is followed by 0x000. page_sel_i and target_i are ignored.
- R7: Code 3'b111 (hold) leaves pc_o unchanged.
- R8: The return stack holds 8 entries in LIFO order. A ninth nested call silently discards the oldest entry, and the 8 newest entries still return in reverse order of their calls.
- R9: A return resumes in the page its call was made from, even when page_sel_i was changed between the call and the return.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Next-address operation code |
| target_i | input | 10 | In-page target for jump, call and computed write |
| page_sel_i | input | 1 | Page-select bit from the status register |
| pc_o | output | 11 | Current instruction address |

## Verification
Every stored value of this unit reaches pc_o. A bad counter update is seen on the clock after the operation that caused it. A corrupted stack entry or pointer stays hidden until the matching return, possibly many cycles later. That return then shows up as a wrong address, often one in the wrong page. The reference model is therefore compared on every clock. The runs include deep nesting, overflow and returns made with a page-select value that differs from the one used at call time. These expose stack faults promptly, rather than only at a single check point.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  localparam int PCU_ADDR_W = 11;
  localparam int PCU_STACK_DEPTH = 8;

  typedef enum logic [2:0] {
    PCU_STEP  = 3'd0,
    PCU_JUMP  = 3'd1,
    PCU_CALL  = 3'd2,
    PCU_RET   = 3'd3,
    PCU_RETLT = 3'd4,
    PCU_RETIN = 3'd5,
    PCU_WRLO  = 3'd6,
    PCU_HOLD  = 3'd7
  } pcu_op_e;

  function automatic logic pcu_is_return(input pcu_op_e op);
    return (op == PCU_RET) || (op == PCU_RETLT) || (op == PCU_RETIN);
  endfunction

endpackage

// File: rtl/pcu_next.sv
module pcu_next
  import pcu_pkg::*;
#(
  parameter int ADDR_W = PCU_ADDR_W
) (
  input  pcu_op_e           op_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-2:0] target_i,
  input  logic              page_i,
  input  logic [ADDR_W-1:0] saved_i,
  output logic [ADDR_W-1:0] next_o,
  output logic              push_o,
  output logic              pop_o,
  output logic [ADDR_W-1:0] link_o
);

  // sequential successor, wraps in the full address space
  function automatic logic [ADDR_W-1:0] seq_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  // page bit on top of an in-page target
  function automatic logic [ADDR_W-1:0] paged_addr(input logic p,
                                                   input logic [ADDR_W-2:0] t);
    return {p, t};
  endfunction

  assign link_o = seq_addr(pc_i);
  assign push_o = (op_i == PCU_CALL);
  assign pop_o  = pcu_is_return(op_i);

  always_comb begin
    unique case (op_i)
      PCU_STEP:                    next_o = seq_addr(pc_i);
      PCU_JUMP, PCU_CALL, PCU_WRLO: next_o = paged_addr(page_i, target_i);
      PCU_RET, PCU_RETLT, PCU_RETIN: next_o = saved_i;
      default:                     next_o = pc_i;
    endcase
  end

endmodule

// File: rtl/pcu_stack.sv
module pcu_stack
  import pcu_pkg::*;
#(
  parameter int ADDR_W = PCU_ADDR_W,
  parameter int DEPTH  = PCU_STACK_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] data_i,
  output logic [ADDR_W-1:0] top_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ADDR_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q;
  logic [PTR_W-1:0]  top_ptr;

  function automatic logic [PTR_W-1:0] ring_inc(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] ring_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(DEPTH - 1) : p - PTR_W'(1);
  endfunction

  assign top_ptr = ring_dec(wr_ptr_q);
  assign top_o   = slot_q[top_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
    end else if (push_i) begin
      wr_ptr_q <= ring_inc(wr_ptr_q);
    end else if (pop_i) begin
      wr_ptr_q <= top_ptr;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (push_i && (int'(wr_ptr_q) == g)) begin
        slot_q[g] <= data_i;
      end
    end
  end

  // R8: a pushed address is what a following return sees
  a_r8_push_on_top: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> top_o == $past(data_i));

endmodule

// File: rtl/pc_paged_unit.sv
module pc_paged_unit
  import pcu_pkg::*;
#(
  parameter int ADDR_W = PCU_ADDR_W,
  parameter int DEPTH  = PCU_STACK_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_i,
  input  logic [ADDR_W-2:0] target_i,
  input  logic              page_sel_i,
  output logic [ADDR_W-1:0] pc_o
);

  localparam logic [ADDR_W-1:0] RESET_VEC = '1;

  pcu_op_e           op;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_next;
  logic [ADDR_W-1:0] stack_top;
  logic [ADDR_W-1:0] link_addr;
  logic              call_evt;
  logic              ret_evt;

  assign op = pcu_op_e'(op_i);

  pcu_next #(.ADDR_W(ADDR_W)) u_next (
    .op_i     (op),
    .pc_i     (pc_q),
    .target_i (target_i),
    .page_i   (page_sel_i),
    .saved_i  (stack_top),
    .next_o   (pc_next),
    .push_o   (call_evt),
    .pop_o    (ret_evt),
    .link_o   (link_addr)
  );

  pcu_stack #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_stack (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (call_evt),
    .pop_i  (ret_evt),
    .data_i (link_addr),
    .top_o  (stack_top)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_VEC;
    else        pc_q <= pc_next;
  end

  assign pc_o = pc_q;

  // R2: jump merges the page bit
  a_r2_jump_paged: assert property (@(posedge clk) disable iff (!rst_n)
    (op == PCU_JUMP) |=> pc_o == {$past(page_sel_i), $past(target_i)});

  // R4: computed write merges the page bit
  a_r4_write_paged: assert property (@(posedge clk) disable iff (!rst_n)
    (op == PCU_WRLO) |=> pc_o == {$past(page_sel_i), $past(target_i)});

  // R3: the stack top after a call is the old address plus one
  a_r3_call_link: assert property (@(posedge clk) disable iff (!rst_n)
    call_evt |=> stack_top == ADDR_W'($past(pc_o) + 1'b1));

  // R5: a return resumes at the saved address
  a_r5_ret_resume: assert property (@(posedge clk) disable iff (!rst_n)
    ret_evt |=> pc_o == $past(stack_top));

  // R6: step advances by one
  a_r6_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (op == PCU_STEP) |=> pc_o == ADDR_W'($past(pc_o) + 1'b1));

  // R7: hold keeps the address
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (op == PCU_HOLD) |=> $stable(pc_o));

endmodule

// File: tb/tb_pc_paged_unit.sv
module tb_pc_paged_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op_i = 3'd7;
  logic [9:0] target_i = '0;
  logic       page_sel_i = 1'b0;
  logic [10:0] pc_o;

  int checks = 0;
  int failures = 0;
  int pc_m = 0;
  int stk[$];

  always #10 clk = ~clk;

  pc_paged_unit dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_i       (op_i),
    .target_i   (target_i),
    .page_sel_i (page_sel_i),
    .pc_o       (pc_o)
  );

  task automatic check(input string req);
    checks++;
    if (int'(pc_o) != pc_m) begin
      failures++;
      $display("FAIL %s: pc_o=%03h expected %03h", req, pc_o, pc_m);
    end
  endtask

  // behavioural reference: applied at the same edge the DUT sees
  task automatic model(input int op, input int t, input int pg);
    case (op)
      0: pc_m = (pc_m + 1) % 2048;
      1, 6: pc_m = pg * 1024 + t;
      2: begin
        stk.push_back((pc_m + 1) % 2048);
        if (stk.size() > 8) void'(stk.pop_front());
        pc_m = pg * 1024 + t;
      end
      3, 4, 5: pc_m = stk.pop_back();
      default: ;
    endcase
  endtask

  task automatic do_op(input int op, input int t, input int pg, input string req);
    op_i = 3'(op);
    target_i = 10'(t);
    page_sel_i = pg[0];
    @(posedge clk);
    model(op, t, pg);
    @(negedge clk);
    check(req);
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    op_i = 3'd7;
    repeat (3) @(negedge clk);
    pc_m = 2047;
    stk.delete();
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    apply_reset();
    check("R1");
    // R1: return straight after reset reads a cleared entry
    op_i = 3'd3;
    @(posedge clk);
    pc_m = 0;
    @(negedge clk);
    check("R1");

    apply_reset();
    // R6: wrap from top of memory, page select ignored
    do_op(0, 10'h155, 1, "R6");
    do_op(0, 10'h2aa, 0, "R6");
    // R2: jump into both pages
    do_op(1, 10'h3f0, 1, "R2");
    do_op(1, 10'h012, 0, "R2");
    do_op(6, 10'h1ff, 1, "R4");
    do_op(0, 0, 0, "R6");
    // R7: hold
    do_op(7, 10'h3ff, 1, "R7");
    do_op(7, 10'h000, 0, "R7");
    // R4: computed write, then a return must skip it
    do_op(2, 10'h100, 0, "R3");
    do_op(6, 10'h222, 1, "R4");
    do_op(4, 10'h0aa, 0, "R5");
    // R9: call from page 1 into page 0, return with page select 0
    do_op(1, 10'h050, 1, "R2");
    do_op(2, 10'h020, 0, "R3");
    do_op(0, 0, 0, "R6");
    do_op(5, 10'h3ff, 0, "R9");
    // R9: call from page 0 into page 1, return with page select 1
    do_op(1, 10'h007, 0, "R2");
    do_op(2, 10'h300, 1, "R3");
    do_op(3, 10'h000, 1, "R9");
    // R8: nine nested calls, eight returns
    for (int i = 0; i < 9; i++) do_op(2, 16 * i + 3, i % 2, "R8");
    for (int i = 0; i < 8; i++) do_op(3 + (i % 3), 10'h3c3, ~i % 2, "R8");
    // mixed traffic, no underflow
    for (int i = 0; i < 3000; i++) begin
      int op = int'($urandom_range(0, 7));
      if (op >= 3 && op <= 5 && stk.size() == 0) op = 0;
      do_op(op, int'($urandom_range(0, 1023)), int'($urandom_range(0, 1)), "R5");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule